// File: doc/BRIEF.md
# Keyed-Stop Watchdog Reset Timer

This block is a watchdog timer that counts down in prescaled ticks and, when it runs out, drives a chip-reset pulse of fixed length. Software reaches it through a byte-wide register write port and a combinational read port. The reload value, the prescaler ratio and the clock-source option each have their own register. A control/status register carries a self-clearing restart bit, a sticky expiry flag and a read-only active flag.

The countdown cannot be halted by one stray write. Software must send a three-byte key to a write-only key register to stop it. Any later restart re-arms it. The tick source is either the block clock on every cycle or an external timer-0 tick enable, chosen by a configuration bit.

After a power-on reset the timer is idle and waits for its first restart. A reload count of 1 followed by a restart gives a forced reset one tick later. The surrounding logic is expected to apply a synchronized `rst_n`, and to route `chip_rst_o` into the chip's reset tree without feeding it back into `rst_n`. The sticky flag therefore survives the pulse.

Top module: `wdt_keyed_timer`

## Requirements
- R1: After `rst_n` is released, `chip_rst_o` is 0 and the register reads return 0: configuration (address 1), prescaler (address 2), count (address 3) and control/status (address 4, bit 0 restart-pending, bit 1 expired, bit 2 active).
- R2: Writing a byte with bit 0 set to address 4 sets restart-pending. The bit reads 1 until the reload is applied at the next source tick, then clears by itself. When the reload is applied, active becomes 1.
- R3: After a reload with count N (N=0 behaves as 1) and prescaler P, the timer expires N·(P+1) source ticks later. With the clock source, `chip_rst_o` is first seen high N·(P+1)+1 cycles after the cycle that sampled the restart write.
- R4: A prescaler value of 0 gives one watchdog tick per source tick. With count 1, the reset therefore starts on the second clock edge after the restart write.
- R5: On expiry `chip_rst_o` goes high for exactly RST_LEN (default 4) cycles, once, and active reads 0.
- R6: Expiry sets the expired bit (address 4, bit 1). The bit holds until a write to address 4 with bit 1 set clears it. Writing 0 to that bit leaves it set.
- R7: Writing 0x87, 0x61 and 0x63 in that order to address 0 stops the countdown: active reads 0 and no reset pulse follows.
- R8: A wrong byte written to address 0 in the middle of the key sends the detector back to its start. A wrong byte equal to 0x87 counts as a new first byte.
- R9: A restart issued after a stop re-arms the countdown with the current count and prescaler.
- R10: Configuration bit 0 set selects `tmr_tick_i` as the source tick, and restart-pending then stays 1 until a tick arrives. The register holds the full byte written, and writing 0 clears all its bits.
- R11: A restart while the timer is active reloads it, so expiry moves to N·(P+1)+1 cycles after the new restart write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| tmr_tick_i | input | 1 | Timer-0 tick enable, used as source tick when configuration bit 0 is set |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data (combinational) |
| chip_rst_o | output | 1 | Chip reset pulse, high for RST_LEN cycles on expiry |

## Verification
The prescaler or countdown holding a wrong value shows up at the ports as a reset pulse that starts early or late. The bench measures its start to the exact cycle for several count and prescaler pairs, so an off-by-one shows within the first vector. A key detector stuck in a wrong state shows as the active bit staying 1 after a correct key, or going 0 after a broken one. This is read back in the cycle after the last key write, and confirmed by a reset pulse that must or must not appear within a few hundred cycles. A stuck restart-pending or expired bit shows in the next read of address 4.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_KEY = 3'd0,
    A_CFG = 3'd1,
    A_PRE = 3'd2,
    A_CNT = 3'd3,
    A_CSR = 3'd4
  } reg_addr_e;

  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h61;
  localparam logic [7:0] KEY_B2 = 8'h63;

  typedef enum logic [1:0] {
    K_IDLE = 2'd0,
    K_ONE  = 2'd1,
    K_TWO  = 2'd2
  } key_st_e;
endpackage

// File: rtl/wdt_key_det.sv
module wdt_key_det
  import wdt_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic [DW-1:0] key_data,
  output logic          stop_o
);
  key_st_e st_q, st_d;
  logic    is_b0, is_b1, is_b2;

  assign is_b0 = (key_data[7:0] == KEY_B0);
  assign is_b1 = (key_data[7:0] == KEY_B1);
  assign is_b2 = (key_data[7:0] == KEY_B2);

  always_comb begin
    st_d   = st_q;
    stop_o = 1'b0;
    if (key_wr) begin
      unique case (st_q)
        K_IDLE:  st_d = is_b0 ? K_ONE : K_IDLE;
        K_ONE:   st_d = is_b1 ? K_TWO : (is_b0 ? K_ONE : K_IDLE);
        K_TWO: begin
          if (is_b2) begin
            stop_o = 1'b1;
            st_d   = K_IDLE;
          end else begin
            st_d = is_b0 ? K_ONE : K_IDLE;
          end
        end
        default: st_d = K_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= K_IDLE;
    else if (key_wr) st_q <= st_d;
  end

  // R8: a completed key always returns the detector to its start
  a_r8_key_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |=> (st_q == K_IDLE));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_tick,
  input  logic          load,
  input  logic          run,
  input  logic [DW-1:0] pre_val,
  output logic          tick_o
);
  logic [DW-1:0] pre_q, pre_d;
  logic          pre_en;

  assign tick_o = run && src_tick && (pre_q == '0);
  assign pre_en = load || (run && src_tick);

  always_comb begin
    pre_d = pre_q;
    if (load)                pre_d = pre_val;
    else if (pre_q == '0)    pre_d = pre_val;
    else                     pre_d = pre_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int DW      = 8,
  parameter int RST_LEN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          stop_i,
  input  logic          tick,
  input  logic [DW-1:0] cnt_val,
  output logic          active_o,
  output logic          expire_o,
  output logic          rst_o
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic [PW-1:0] pls_q, pls_d;

  assign expire_o = act_q && tick && (cnt_q <= DW'(1));
  assign active_o = act_q;
  assign rst_o    = (pls_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (stop_i) begin
      act_d = 1'b0;
    end else if (load) begin
      cnt_d = cnt_val;
      act_d = 1'b1;
    end else if (expire_o) begin
      cnt_d = '0;
      act_d = 1'b0;
    end else if (act_q && tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_comb begin
    pls_d = pls_q;
    if (expire_o && !stop_i && !load) pls_d = PW'(RST_LEN);
    else if (pls_q != '0)             pls_d = pls_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
      pls_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
      pls_q <= pls_d;
    end
  end

  // R5: a reset pulse only starts as the countdown leaves the active state
  a_r5_idle_at_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> !active_o);

  // R7: the countdown only goes idle through expiry or a key stop
  a_r7_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> (rst_o || $past(stop_i)));
endmodule

// File: rtl/wdt_keyed_timer.sv
module wdt_keyed_timer
  import wdt_pkg::*;
#(
  parameter int DW      = 8,
  parameter int RST_LEN = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_tick_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  output logic              chip_rst_o
);
  logic [DW-1:0] cfg_q, pre_q, cnt_q;
  logic          pend_q, pend_d;
  logic          sts_q, sts_d;
  logic          wr_key, wr_cfg, wr_pre, wr_cnt, wr_csr;
  logic          src_tick, load, stop, wd_tick, active, expire;

  assign wr_key = wr_en && (wr_addr == A_KEY);
  assign wr_cfg = wr_en && (wr_addr == A_CFG);
  assign wr_pre = wr_en && (wr_addr == A_PRE);
  assign wr_cnt = wr_en && (wr_addr == A_CNT);
  assign wr_csr = wr_en && (wr_addr == A_CSR);

  assign src_tick = cfg_q[0] ? tmr_tick_i : 1'b1;
  assign load     = pend_q && src_tick;

  always_comb begin
    pend_d = pend_q;
    if (wr_csr && wr_data[0]) pend_d = 1'b1;
    else if (load)            pend_d = 1'b0;
  end

  always_comb begin
    sts_d = sts_q;
    if (expire)                    sts_d = 1'b1;
    else if (wr_csr && wr_data[1]) sts_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      pre_q  <= '0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
      sts_q  <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= wr_data;
      if (wr_pre) pre_q <= wr_data;
      if (wr_cnt) cnt_q <= wr_data;
      pend_q <= pend_d;
      sts_q  <= sts_d;
    end
  end

  always_comb begin
    unique case (rd_addr)
      A_CFG:   rd_data = cfg_q;
      A_PRE:   rd_data = pre_q;
      A_CNT:   rd_data = cnt_q;
      A_CSR:   rd_data = {{(DW-3){1'b0}}, active, sts_q, pend_q};
      default: rd_data = '0;
    endcase
  end

  wdt_key_det #(.DW(DW)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (wr_key),
    .key_data (wr_data),
    .stop_o   (stop)
  );

  wdt_prescaler #(.DW(DW)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .load     (load),
    .run      (active),
    .pre_val  (pre_q),
    .tick_o   (wd_tick)
  );

  wdt_countdown #(.DW(DW), .RST_LEN(RST_LEN)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .stop_i   (stop),
    .tick     (wd_tick),
    .cnt_val  (cnt_q),
    .active_o (active),
    .expire_o (expire),
    .rst_o    (chip_rst_o)
  );

  // R2: a pending restart is consumed by the first source tick
  a_r2_pend_served: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && src_tick && !(wr_csr && wr_data[0])) |=> !pend_q);

  // R2: a consumed restart leaves the countdown active unless stopped
  a_r2_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !stop) |=> active);

  // R6: every reset pulse is accompanied by the expired flag
  a_r6_sts_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chip_rst_o) |-> sts_q);
endmodule

// File: tb/wdt_keyed_timer_bench.sv
module wdt_keyed_timer_bench;
  localparam int DW      = 8;
  localparam int RST_LEN = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tmr_tick_i = 1'b0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [2:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          chip_rst_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  wdt_keyed_timer #(.DW(DW), .RST_LEN(RST_LEN)) u_wdt_keyed_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tmr_tick_i (tmr_tick_i),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .chip_rst_o (chip_rst_o)
  );

  // {count, prescaler, cycles from sampled restart to first high reset}
  localparam logic [23:0] VEC [5] = '{
    {8'd1, 8'd0, 8'd2},
    {8'd3, 8'd0, 8'd4},
    {8'd2, 8'd2, 8'd7},
    {8'd0, 8'd1, 8'd3},
    {8'd5, 8'd3, 8'd21}
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic wait_rst(input int lim, output int k);
    k = 0;
    while (k <= lim) begin
      @(negedge clk);
      k++;
      if (chip_rst_o) break;
    end
  endtask

  task automatic pulse_len(output int n);
    n = 1;
    while (n < 50) begin
      @(negedge clk);
      if (!chip_rst_o) break;
      n++;
    end
  endtask

  task automatic key(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    wr(3'd0, a); wr(3'd0, b); wr(3'd0, c);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int k, n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(chip_rst_o == 1'b0, "R1 rst low", chip_rst_o, 0);
    for (int a = 1; a <= 4; a++) begin
      rd(3'(a), d);
      check(d == '0, "R1 reg zero", d, 0);
    end

    // R3/R4/R5/R6: vector table
    for (int i = 0; i < 5; i++) begin
      wr(3'd2, VEC[i][15:8]);
      wr(3'd3, VEC[i][23:16]);
      wr(3'd4, 8'h01);
      rd(3'd4, d);
      check(d[0] == 1'b1, "R2 pending after write", d[0], 1);
      wait_rst(60, k);
      check(k == int'(VEC[i][7:0]), "R3 R4 expiry cycle", k, VEC[i][7:0]);
      pulse_len(n);
      check(n == RST_LEN, "R5 pulse length", n, RST_LEN);
      rd(3'd4, d);
      check(d[2:0] == 3'b010, "R5 R6 csr after expiry", d[2:0], 2);
      wr(3'd4, 8'h00);
      rd(3'd4, d);
      check(d[1] == 1'b1, "R6 zero write keeps flag", d[1], 1);
      wr(3'd4, 8'h02);
      rd(3'd4, d);
      check(d[1] == 1'b0, "R6 w1c clears flag", d[1], 0);
      wait_rst(20, k);
      check(k == 21, "R5 single pulse", k, 21);
    end

    // R2: pending clears and active sets after one cycle
    wr(3'd2, 8'd0); wr(3'd3, 8'd50);
    wr(3'd4, 8'h01);
    @(negedge clk);
    rd(3'd4, d);
    check(d[2:0] == 3'b100, "R2 reload applied", d[2:0], 4);

    // R7: full key stops
    key(8'h87, 8'h61, 8'h63);
    rd(3'd4, d);
    check(d[2] == 1'b0, "R7 stopped", d[2], 0);
    wait_rst(200, k);
    check(k == 201, "R7 no pulse after stop", k, 201);

    // R9: restart after stop re-arms
    wr(3'd3, 8'd3);
    wr(3'd4, 8'h01);
    wait_rst(60, k);
    check(k == 4, "R9 rearm expiry", k, 4);
    pulse_len(n);
    wr(3'd4, 8'h02);

    // R8: broken key does not stop
    wr(3'd3, 8'd100);
    wr(3'd4, 8'h01);
    wr(3'd0, 8'h87); wr(3'd0, 8'h00); wr(3'd0, 8'h61); wr(3'd0, 8'h63);
    rd(3'd4, d);
    check(d[2] == 1'b1, "R8 broken key ignored", d[2], 1);
    // R8: repeated first byte starts a new key
    wr(3'd0, 8'h87);
    key(8'h87, 8'h61, 8'h63);
    rd(3'd4, d);
    check(d[2] == 1'b0, "R8 repeated first byte stops", d[2], 0);

    // R11: kick while active
    wr(3'd3, 8'd10);
    wr(3'd4, 8'h01);
    repeat (6) @(negedge clk);
    check(chip_rst_o == 1'b0, "R11 no early pulse", chip_rst_o, 0);
    wr(3'd4, 8'h01);
    wait_rst(60, k);
    check(k == 11, "R11 expiry after kick", k, 11);
    pulse_len(n);
    wr(3'd4, 8'h02);

    // R10: configuration register and tick source
    wr(3'd1, 8'hA5);
    rd(3'd1, d);
    check(d == 8'hA5, "R10 cfg holds byte", d, 8'hA5);
    wr(3'd1, 8'h00);
    rd(3'd1, d);
    check(d == 8'h00, "R10 cfg zero clears", d, 0);
    wr(3'd1, 8'h01);
    wr(3'd3, 8'd2);
    wr(3'd4, 8'h01);
    repeat (5) @(negedge clk);
    rd(3'd4, d);
    check(d[2:0] == 3'b001, "R10 waits for tick", d[2:0], 1);
    @(negedge clk); tmr_tick_i = 1'b1;
    @(negedge clk); tmr_tick_i = 1'b0;
    rd(3'd4, d);
    check(d[2:0] == 3'b100, "R10 tick loads", d[2:0], 4);
    @(negedge clk); tmr_tick_i = 1'b1;
    @(negedge clk); tmr_tick_i = 1'b0;
    repeat (3) @(negedge clk);
    check(chip_rst_o == 1'b0, "R10 one tick no pulse", chip_rst_o, 0);
    tmr_tick_i = 1'b1;
    @(negedge clk); tmr_tick_i = 1'b0;
    check(chip_rst_o == 1'b1, "R10 second tick pulse", chip_rst_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule